// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block decides which of five candidate reference clocks drives a clock path. It serves two independent paths, a main path and an auxiliary path. Each path has its own mode bit and its own direct-select field. Each path also holds its own set of five priorities. A small register window reaches all of these settings. The clock multiplexer downstream uses the chosen index. The input quality monitor upstream supplies one validity bit per candidate. The selector does not see the clocks themselves, only configuration and status.

In direct (forced) mode a path takes its index straight from its select field, and the monitor results are ignored. In automatic mode a path picks the best qualified candidate. A candidate is qualified when three things hold:
- the monitor marks it valid;
- its priority is nonzero;
- its lock-allowance bit is clear.

A lower nonzero priority value wins. When priorities are equal, the lower input number wins. The priority words are banked per path. A path-select bit in the window decides which path's priorities a priority address writes and reads.

Each path registers its result once per clock. It reports the chosen index (1 to 5), a no-reference flag, and a one-cycle pulse whenever the index changes.

Top module: `ref_clk_selector`

## Requirements
- R1: In direct mode, when the select field holds a value from 1 to 5, the path outputs that index with the no-reference flag low one cycle after the field takes effect. Monitor validity has no effect in this case.
- R2: In direct mode, a select value of 0 or of 6 to 15 gives index 0 with the no-reference flag high.
- R3: In automatic mode, input n is a candidate only if three conditions hold: monitor bit n-1 is 1, its priority is not 0, and allowance-register bit n-1 is 0. A priority of 0 removes the input.
- R4: Among candidates, the path selects the one with the smallest priority value (1 is best, 15 worst).
- R5: When several candidates share the smallest priority value, the path selects the lowest-numbered one.
- R6: In automatic mode with no candidate, the no-reference flag is high and the index keeps its previous value.
- R7: The change output is high for exactly the cycle in which the registered index differs from its value one cycle earlier.
- R8: Register 0 bit 0 is the path select (0 main, 1 auxiliary). It steers writes and reads at the priority addresses to that path's priorities only; the other path's settings are untouched.
- R9: The register map is as follows.
  - Address 1 is the main mode word and address 2 the auxiliary mode word. Bit 4 is automatic mode and bits 3:0 are the select field.
  - Address 3 holds the allowance bits 4:0.
  - Addresses 4, 5 and 6 hold priorities for inputs {2,1}, {4,3} and {–,5}, with the lower input in bits 3:0.
  - Read data appears one cycle after the address.
- R10: Synchronous reset clears every register. Both paths then show index 0, no-reference high and change low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, one cycle after address |
| mon_valid | input | 5 | Per-input validity from the quality monitor |
| main_sel | output | 3 | Main path selected input (0 = none) |
| main_none | output | 1 | Main path has no reference |
| main_chg | output | 1 | Main path selection changed pulse |
| aux_sel | output | 3 | Auxiliary path selected input (0 = none) |
| aux_none | output | 1 | Auxiliary path has no reference |
| aux_chg | output | 1 | Auxiliary path selection changed pulse |

## Verification
The hardest case to reach is the hold behaviour. A path in automatic mode that loses every candidate must keep the index it had, so the expected value depends on history and not only on the present inputs. The bench reaches this by walking the validity vector through all 32 values, starting from zero, under each combination of priority set and allowance mask. The paths therefore repeatedly fall from a live choice into the empty case and back. A cycle-by-cycle reference model in the bench tracks the held index and the change pulse. The two paths get different priority sets so that any mix-up of the banked priorities shows on the outputs.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  // register addresses (window layout)
  localparam int unsigned ADR_CTL   = 0;
  localparam int unsigned ADR_MAIN  = 1;
  localparam int unsigned ADR_AUX   = 2;
  localparam int unsigned ADR_ALLOW = 3;
  localparam int unsigned ADR_PRIO  = 4;

  typedef enum logic {PATH_MAIN = 1'b0, PATH_AUX = 1'b1} path_e;
endpackage

// File: rtl/ref_sel_regs.sv
module ref_sel_regs
  import ref_sel_pkg::*;
#(
  parameter int NUM_IN = 5,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     main_auto,
  output logic [SEL_W-1:0]         main_force,
  output logic                     aux_auto,
  output logic [SEL_W-1:0]         aux_force,
  output logic [NUM_IN-1:0]        allow,
  output logic [NUM_IN*PRIO_W-1:0] main_prio,
  output logic [NUM_IN*PRIO_W-1:0] aux_prio
);
  localparam int PPW    = DATA_W / PRIO_W;
  localparam int NUM_PW = (NUM_IN + PPW - 1) / PPW;
  localparam int PAD_W  = NUM_PW * DATA_W;

  path_e              path_q;
  logic [SEL_W:0]     main_mode_q, aux_mode_q;
  logic [NUM_IN-1:0]  allow_q;
  logic [NUM_IN*PRIO_W-1:0] pm_q, pa_q;
  logic [PAD_W-1:0]   view_flat;
  logic [DATA_W-1:0]  rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      path_q      <= PATH_MAIN;
      main_mode_q <= '0;
      aux_mode_q  <= '0;
      allow_q     <= '0;
      pm_q        <= '0;
      pa_q        <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(ADR_CTL))   path_q      <= path_e'(wdata[0]);
      if (addr == ADDR_W'(ADR_MAIN))  main_mode_q <= wdata[SEL_W:0];
      if (addr == ADDR_W'(ADR_AUX))   aux_mode_q  <= wdata[SEL_W:0];
      if (addr == ADDR_W'(ADR_ALLOW)) allow_q     <= wdata[NUM_IN-1:0];
      for (int i = 0; i < NUM_IN; i++) begin
        if (addr == ADDR_W'(ADR_PRIO + i / PPW)) begin
          if (path_q == PATH_AUX)
            pa_q[i*PRIO_W +: PRIO_W] <= wdata[(i % PPW)*PRIO_W +: PRIO_W];
          else
            pm_q[i*PRIO_W +: PRIO_W] <= wdata[(i % PPW)*PRIO_W +: PRIO_W];
        end
      end
    end
  end

  assign view_flat = PAD_W'((path_q == PATH_AUX) ? pa_q : pm_q);

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADR_CTL))   rd_next = DATA_W'(path_q);
    if (addr == ADDR_W'(ADR_MAIN))  rd_next = DATA_W'(main_mode_q);
    if (addr == ADDR_W'(ADR_AUX))   rd_next = DATA_W'(aux_mode_q);
    if (addr == ADDR_W'(ADR_ALLOW)) rd_next = DATA_W'(allow_q);
    for (int w = 0; w < NUM_PW; w++)
      if (addr == ADDR_W'(ADR_PRIO + w)) rd_next = view_flat[w*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign main_auto  = main_mode_q[SEL_W];
  assign main_force = main_mode_q[SEL_W-1:0];
  assign aux_auto   = aux_mode_q[SEL_W];
  assign aux_force  = aux_mode_q[SEL_W-1:0];
  assign allow      = allow_q;
  assign main_prio  = pm_q;
  assign aux_prio   = pa_q;
endmodule

// File: rtl/ref_sel_pick.sv
module ref_sel_pick #(
  parameter int NUM_IN = 5,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_IN*PRIO_W-1:0] prio,
  input  logic [NUM_IN-1:0]        valid,
  input  logic [NUM_IN-1:0]        allow,
  output logic                     found,
  output logic [IDX_W-1:0]         best_idx
);
  logic [NUM_IN-1:0] qual;
  logic [PRIO_W-1:0] best_prio;

  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : g_qual
      assign qual[g] = valid[g] && !allow[g] && (prio[g*PRIO_W +: PRIO_W] != '0);
    end
  endgenerate

  // strict compare keeps the lowest index on equal priority
  always_comb begin
    found     = 1'b0;
    best_prio = '1;
    best_idx  = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (qual[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
        found     = 1'b1;
        best_prio = prio[i*PRIO_W +: PRIO_W];
        best_idx  = IDX_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/ref_sel_path.sv
module ref_sel_path #(
  parameter int NUM_IN = 5,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     auto_mode,
  input  logic [SEL_W-1:0]         force_sel,
  input  logic [NUM_IN*PRIO_W-1:0] prio,
  input  logic [NUM_IN-1:0]        valid,
  input  logic [NUM_IN-1:0]        allow,
  output logic [IDX_W-1:0]         sel,
  output logic                     none,
  output logic                     chg
);
  logic             found;
  logic [IDX_W-1:0] best_idx;
  logic [IDX_W-1:0] sel_d;
  logic             none_d;
  logic             force_ok;

  ref_sel_pick #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .prio     (prio),
    .valid    (valid),
    .allow    (allow),
    .found    (found),
    .best_idx (best_idx)
  );

  assign force_ok = (force_sel != '0) && (force_sel <= SEL_W'(NUM_IN));

  always_comb begin
    if (auto_mode) begin
      sel_d  = found ? best_idx : sel;
      none_d = !found;
    end else begin
      sel_d  = force_ok ? IDX_W'(force_sel) : '0;
      none_d = !force_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel  <= '0;
      none <= 1'b1;
      chg  <= 1'b0;
    end else begin
      sel  <= sel_d;
      none <= none_d;
      chg  <= (sel_d != sel);
    end
  end
endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector #(
  parameter int NUM_IN = 5,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 4,
  parameter int IDX_W  = $clog2(NUM_IN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [NUM_IN-1:0] mon_valid,
  output logic [IDX_W-1:0]  main_sel,
  output logic              main_none,
  output logic              main_chg,
  output logic [IDX_W-1:0]  aux_sel,
  output logic              aux_none,
  output logic              aux_chg
);
  logic                     main_auto_w, aux_auto_w;
  logic [SEL_W-1:0]         main_force_w, aux_force_w;
  logic [NUM_IN-1:0]        allow_w;
  logic [NUM_IN*PRIO_W-1:0] main_prio_w, aux_prio_w;

  ref_sel_regs #(
    .NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .main_auto  (main_auto_w),
    .main_force (main_force_w),
    .aux_auto   (aux_auto_w),
    .aux_force  (aux_force_w),
    .allow      (allow_w),
    .main_prio  (main_prio_w),
    .aux_prio   (aux_prio_w)
  );

  ref_sel_path #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_main (
    .clk       (clk),
    .rst       (rst),
    .auto_mode (main_auto_w),
    .force_sel (main_force_w),
    .prio      (main_prio_w),
    .valid     (mon_valid),
    .allow     (allow_w),
    .sel       (main_sel),
    .none      (main_none),
    .chg       (main_chg)
  );

  ref_sel_path #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_aux (
    .clk       (clk),
    .rst       (rst),
    .auto_mode (aux_auto_w),
    .force_sel (aux_force_w),
    .prio      (aux_prio_w),
    .valid     (mon_valid),
    .allow     (allow_w),
    .sel       (aux_sel),
    .none      (aux_none),
    .chg       (aux_chg)
  );
endmodule

// File: rtl/ref_sel_chk.sv
module ref_sel_chk #(
  parameter int NUM_IN = 5,
  parameter int SEL_W  = 4,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_IN-1:0] mon_valid,
  input logic              main_auto,
  input logic [SEL_W-1:0]  main_force,
  input logic              aux_auto,
  input logic [IDX_W-1:0]  main_sel,
  input logic              main_none,
  input logic              main_chg,
  input logic [IDX_W-1:0]  aux_sel,
  input logic              aux_none,
  input logic              aux_chg
);
  // R1
  forced_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!main_auto && main_force != '0 && main_force <= SEL_W'(NUM_IN))
      |=> (main_sel == IDX_W'($past(main_force)) && !main_none));

  // R6
  none_auto_chk: assert property (@(posedge clk) disable iff (rst)
    (main_auto && mon_valid == '0) |=> main_none);

  // R6
  hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (aux_auto && mon_valid == '0) |=> (aux_none && $stable(aux_sel)));

  // R7
  main_chg_chk: assert property (@(posedge clk) disable iff (rst)
    main_chg == (main_sel != $past(main_sel)));

  // R7
  aux_chg_chk: assert property (@(posedge clk) disable iff (rst)
    aux_chg == (aux_sel != $past(aux_sel)));

  // R2
  sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    (main_sel <= IDX_W'(NUM_IN)) && (aux_sel <= IDX_W'(NUM_IN)));

  // R3
  live_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (!main_none |-> main_sel != '0) and (!aux_none |-> aux_sel != '0));
endmodule

bind ref_clk_selector ref_sel_chk #(.NUM_IN(NUM_IN), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mon_valid  (mon_valid),
  .main_auto  (main_auto_w),
  .main_force (main_force_w),
  .aux_auto   (aux_auto_w),
  .main_sel   (main_sel),
  .main_none  (main_none),
  .main_chg   (main_chg),
  .aux_sel    (aux_sel),
  .aux_none   (aux_none),
  .aux_chg    (aux_chg)
);

// File: tb/ref_clk_selector_test.sv
module ref_clk_selector_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, we;
  logic [2:0] addr;
  logic [7:0] wdata;
  wire  [7:0] rdata;
  logic [4:0] valid;
  wire  [2:0] msel, asel;
  wire        mnone, anone, mchg, achg;

  int checks = 0;
  int errors = 0;

  ref_clk_selector uut (
    .clk(clk), .rst(rst), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_rdata(rdata), .mon_valid(valid),
    .main_sel(msel), .main_none(mnone), .main_chg(mchg),
    .aux_sel(asel), .aux_none(anone), .aux_chg(achg)
  );

  // bench-side register shadow and expected outputs
  logic        sh_path;
  logic [4:0]  sh_mmode, sh_amode, sh_allow;
  logic [19:0] sh_pm, sh_pa;
  logic [2:0]  em_sel, ea_sel;
  logic        em_none, ea_none, em_chg, ea_chg;

  // {none, index}; scan priority values best-first, inputs lowest-first
  function automatic logic [3:0] expect_next(input logic [4:0] mode, input logic [19:0] pr,
                                             input logic [4:0] v, input logic [4:0] al,
                                             input logic [2:0] prev);
    if (mode[4]) begin
      for (int p = 1; p < 16; p++)
        for (int i = 0; i < 5; i++)
          if (v[i] && !al[i] && pr[i*4 +: 4] == 4'(p)) return {1'b0, 3'(i + 1)};
      return {1'b1, prev};
    end
    if (mode[3:0] >= 4'd1 && mode[3:0] <= 4'd5) return {1'b0, mode[2:0]};
    return {1'b1, 3'd0};
  endfunction

  always @(posedge clk) begin
    logic [3:0] nm, na;
    if (rst) begin
      sh_path <= 0; sh_mmode <= 0; sh_amode <= 0; sh_allow <= 0; sh_pm <= 0; sh_pa <= 0;
      em_sel <= 0; em_none <= 1; em_chg <= 0;
      ea_sel <= 0; ea_none <= 1; ea_chg <= 0;
    end else begin
      nm = expect_next(sh_mmode, sh_pm, valid, sh_allow, em_sel);
      na = expect_next(sh_amode, sh_pa, valid, sh_allow, ea_sel);
      em_sel <= nm[2:0]; em_none <= nm[3]; em_chg <= (nm[2:0] != em_sel);
      ea_sel <= na[2:0]; ea_none <= na[3]; ea_chg <= (na[2:0] != ea_sel);
      if (we) begin
        case (addr)
          3'd0: sh_path  <= wdata[0];
          3'd1: sh_mmode <= wdata[4:0];
          3'd2: sh_amode <= wdata[4:0];
          3'd3: sh_allow <= wdata[4:0];
          3'd4: if (sh_path) sh_pa[7:0]   <= wdata; else sh_pm[7:0]   <= wdata;
          3'd5: if (sh_path) sh_pa[15:8]  <= wdata; else sh_pm[15:8]  <= wdata;
          3'd6: if (sh_path) sh_pa[19:16] <= wdata[3:0]; else sh_pm[19:16] <= wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_paths(input string tag);
    chk({tag, " main index"}, 8'(msel), 8'(em_sel));
    chk({tag, " main none"}, 8'(mnone), 8'(em_none));
    chk("R7 main change", 8'(mchg), 8'(em_chg));
    chk({tag, " aux index"}, 8'(asel), 8'(ea_sel));
    chk({tag, " aux none"}, 8'(anone), 8'(ea_none));
    chk("R7 aux change", 8'(achg), 8'(ea_chg));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); we = 1'b0; addr = a;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic load_prio(input logic p, input logic [19:0] pr);
    wr(3'd0, {7'd0, p});
    wr(3'd4, pr[7:0]);
    wr(3'd5, pr[15:8]);
    wr(3'd6, {4'h0, pr[19:16]});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  logic [19:0] mset [4];
  logic [19:0] aset [4];
  logic [4:0]  aset_allow [4];
  logic [4:0]  vpat [4];

  initial begin
    mset[0] = 20'h12345; mset[1] = 20'h77777; mset[2] = 20'h93030; mset[3] = 20'hF1F1E;
    aset[0] = 20'h54321; aset[1] = 20'h22922; aset[2] = 20'h0A0B0; aset[3] = 20'h88118;
    aset_allow[0] = 5'h00; aset_allow[1] = 5'h04; aset_allow[2] = 5'h11; aset_allow[3] = 5'h1F;
    vpat[0] = 5'h00; vpat[1] = 5'h1F; vpat[2] = 5'h0A; vpat[3] = 5'h15;

    rst = 1'b1; we = 1'b0; addr = 3'd0; wdata = 8'd0; valid = 5'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check_paths("R10");
    rst = 1'b0;
    for (int a = 0; a < 7; a++) rd(3'(a), 8'h00, "R10 register clear");

    // R1 / R2 direct mode over every select value, validity varied
    for (int f = 0; f < 16; f++) begin
      wr(3'd1, 8'(f));
      wr(3'd2, 8'(15 - f));
      for (int k = 0; k < 4; k++) begin
        valid = vpat[k];
        @(negedge clk);
        check_paths((f >= 1 && f <= 5) ? "R1" : "R2");
      end
    end

    // R8 / R9 banked priorities and readback
    load_prio(1'b0, 20'h00021);
    load_prio(1'b1, 20'h00043);
    rd(3'd4, 8'h43, "R8 aux bank read");
    rd(3'd0, 8'h01, "R9 path bit read");
    wr(3'd0, 8'h00);
    rd(3'd4, 8'h21, "R8 main bank untouched");
    wr(3'd6, 8'hFA);
    rd(3'd6, 8'h0A, "R9 upper nibble of last word");
    rd(3'd1, 8'h0F, "R9 main mode read");
    rd(3'd2, 8'h00, "R9 aux mode read");
    wr(3'd3, 8'h0A);
    rd(3'd3, 8'h0A, "R9 allowance read");

    // R3..R7 automatic mode sweep
    for (int s = 0; s < 4; s++) begin
      for (int al = 0; al < 4; al++) begin
        load_prio(1'b0, mset[s]);
        load_prio(1'b1, aset[s]);
        wr(3'd3, {3'd0, aset_allow[al]});
        wr(3'd1, 8'h10);
        wr(3'd2, 8'h10);
        for (int v = 0; v < 32; v++) begin
          valid = 5'(v);
          @(negedge clk);
          if (em_none || ea_none)  check_paths("R6");
          else if (s == 1)         check_paths("R5");
          else if (al != 0 || s == 2) check_paths("R3");
          else                     check_paths("R4");
        end
      end
    end

    finish_run();
  end
endmodule